// File: doc/BRIEF.md
# Pipelined Polar-to-Cartesian Converter

This block turns a polar sample (an unsigned magnitude and a phase angle) into the matching Cartesian pair. It returns x = A·cos θ on the I lane and y = A·sin θ on the Q lane. It accepts a new sample on every clock. Each result leaves a fixed number of clocks later, so a steadily advancing phase gives a quadrature cosine/sine pair whose scale is set by the magnitude.

The angle is a binary fraction of a full turn. Only its upper 24 bits are used. The first stage folds the angle to the nearest quarter turn, which leaves a residual within ±45 degrees. A chain of shift-and-add micro-rotations on 24-bit words then removes that residual. A constant multiply cancels the rotation gain, and the result is rounded to 16 bits. A last stage encodes each lane as offset binary or as a flagged magnitude. The format flag travels down the pipeline with its own sample. Each lane also has its own active-low output enable.

Top module: `polar_rect_cordic`

## Requirements
- R1: A sample presented at rising edge E (the first edge) appears on `i_out`/`q_out` right after the 22nd rising edge counted from E, that is edge E+21. Successive samples come out on successive clocks.
- R2: The angle is θ = 2π·phase_in[31:8]/2^24 and increases counterclockwise. The signed I value is within 2 LSB of A·cos θ and the signed Q value is within 2 LSB of A·sin θ, where A = amp_in.
- R3: The angle wraps modulo one full turn, so phase_in[31] may be read as a sign or as a half turn. Results stay correct across every quarter-turn and octant boundary. The residual entering the micro-rotations stays within ±2^21 angle units.
- R4: Each signed lane value is saturated to the range -32767..+32767. The code for -32768 (offset code 0x0000) never appears.
- R5: With `fmt_obin` = 1, a lane code equals the signed value plus 0x8000. Bit 15 is therefore 0 for a negative value and 1 otherwise.
- R6: With `fmt_obin` = 0, bits 14:0 of a lane hold the absolute value and bit 15 is 1.
- R7: `fmt_obin` is sampled together with the amplitude and phase. It governs only the result of that same sample, even when it changes every clock.
- R8: `oe_i_n` low drives `i_out` and sets `i_en`. When `oe_i_n` is high, `i_en` is 0 and `i_out` reads 0. `oe_q_n` acts in the same way on the Q lane. Both enables are combinational and independent of each other.
- R9: While `rst_n` is low, and after it is released until the first sample has passed through, both lanes read 0x8000, which is the zero value in either format.
- R10: phase_in[7:0] has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| amp_in | input | 15 | Unsigned magnitude |
| phase_in | input | 32 | Angle as a fraction of a full turn; upper 24 bits used |
| fmt_obin | input | 1 | 1 = offset binary, 0 = flagged magnitude; travels with the sample |
| oe_i_n | input | 1 | I lane output enable, active low |
| oe_q_n | input | 1 | Q lane output enable, active low |
| i_out | output | 16 | x coordinate code |
| q_out | output | 16 | y coordinate code |
| i_en | output | 1 | High while I lane is driven |
| q_en | output | 1 | High while Q lane is driven |

## Verification
Two things happen in the same clock at the output. A sample with one format flag leaves the pipeline while samples with the other flag are still inside it, and that same clock can also see an enable change. The bench runs a full-turn sweep in which the format flag flips on every sample, and it judges each output word by the flag of the sample that produced it. In a separate step, one enable is released while the other lane stays driven with a live value, and the driven lane must stay correct.

// File: rtl/p2r_pkg.sv
package p2r_pkg;

    localparam int GAIN_FRAC = 17;
    // round(0.6072529350 * 2^17): inverse of the rotation gain
    localparam int GAIN_Q    = 79594;

    // Arctangent of 2^-idx, in units of 2^-24 of a full turn,
    // rescaled to an ang_w-bit angle (ang_w <= 24).
    function automatic int atan_step(input int idx, input int ang_w);
        int base;
        case (idx)
            0:       base = 2097152;
            1:       base = 1238021;
            2:       base = 654136;
            3:       base = 332050;
            4:       base = 166669;
            5:       base = 83416;
            6:       base = 41718;
            7:       base = 20860;
            8:       base = 10430;
            9:       base = 5215;
            default: base = (2670176 + (1 << (idx - 1))) >> idx;
        endcase
        return base >>> (24 - ang_w);
    endfunction

endpackage

// File: rtl/p2r_quadrant_map.sv
module p2r_quadrant_map #(
    parameter int AMP_W = 15,
    parameter int PH_W  = 32,
    parameter int ANG_W = 24,
    parameter int DW    = 24,
    parameter int GUARD = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AMP_W-1:0]        amp_i,
    input  logic [PH_W-1:0]         phase_i,
    input  logic                    fmt_i,
    output logic signed [DW-1:0]    x_o,
    output logic signed [DW-1:0]    y_o,
    output logic signed [ANG_W-1:0] z_o,
    output logic                    fmt_o
);

    localparam int PAD_W = DW - AMP_W - GUARD;

    typedef struct packed {
        logic [AMP_W-1:0] amp;
        logic [ANG_W-1:0] ang;
        logic             fmt;
    } cap_t;

    typedef struct packed {
        logic [DW-1:0]    x;
        logic [DW-1:0]    y;
        logic [ANG_W-1:0] z;
        logic             fmt;
    } vec_t;

    typedef struct packed {
        cap_t cap;
        vec_t vec;
    } state_t;

    state_t        st_d, st_q;
    logic [1:0]    quad;
    logic [DW-1:0] mag;
    logic          unused_phase_lsb;

    assign unused_phase_lsb = ^phase_i[PH_W-ANG_W-1:0];

    always_comb begin
        st_d         = st_q;
        // stage 1: capture the sample
        st_d.cap.amp = amp_i;
        st_d.cap.ang = phase_i[PH_W-1 -: ANG_W];
        st_d.cap.fmt = fmt_i;
        // stage 2: fold to the nearest quarter turn
        quad         = st_q.cap.ang[ANG_W-1 -: 2] + {1'b0, st_q.cap.ang[ANG_W-3]};
        mag          = {{PAD_W{1'b0}}, st_q.cap.amp, {GUARD{1'b0}}};
        st_d.vec.z   = st_q.cap.ang - {quad, {(ANG_W-2){1'b0}}};
        st_d.vec.fmt = st_q.cap.fmt;
        case (quad)
            2'd0: begin st_d.vec.x = mag;     st_d.vec.y = '0;      end
            2'd1: begin st_d.vec.x = '0;      st_d.vec.y = mag;     end
            2'd2: begin st_d.vec.x = -mag;    st_d.vec.y = '0;      end
            default: begin st_d.vec.x = '0;   st_d.vec.y = -mag;    end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x_o   = $signed(st_q.vec.x);
    assign y_o   = $signed(st_q.vec.y);
    assign z_o   = $signed(st_q.vec.z);
    assign fmt_o = st_q.vec.fmt;

endmodule

// File: rtl/p2r_micro_rot.sv
module p2r_micro_rot #(
    parameter int DW    = 24,
    parameter int ANG_W = 24,
    parameter int IDX   = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [DW-1:0]    x_i,
    input  logic signed [DW-1:0]    y_i,
    input  logic signed [ANG_W-1:0] z_i,
    input  logic                    fmt_i,
    output logic signed [DW-1:0]    x_o,
    output logic signed [DW-1:0]    y_o,
    output logic signed [ANG_W-1:0] z_o,
    output logic                    fmt_o
);

    localparam logic signed [ANG_W-1:0] STEP = ANG_W'(p2r_pkg::atan_step(IDX, ANG_W));

    typedef struct packed {
        logic signed [DW-1:0]    x;
        logic signed [DW-1:0]    y;
        logic signed [ANG_W-1:0] z;
        logic                    fmt;
    } rot_t;

    rot_t st_d, st_q;

    always_comb begin
        st_d.fmt = fmt_i;
        if (!z_i[ANG_W-1]) begin
            st_d.x = x_i - (y_i >>> IDX);
            st_d.y = y_i + (x_i >>> IDX);
            st_d.z = z_i - STEP;
        end else begin
            st_d.x = x_i + (y_i >>> IDX);
            st_d.y = y_i - (x_i >>> IDX);
            st_d.z = z_i + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x_o   = st_q.x;
    assign y_o   = st_q.y;
    assign z_o   = st_q.z;
    assign fmt_o = st_q.fmt;

    generate
        if (IDX == 0) begin : g_entry_check
            localparam logic signed [ANG_W-1:0] OCT = ANG_W'(2 ** (ANG_W - 3));
            AST_RESIDUAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (z_i <= OCT) && (z_i >= -OCT)) else $error("residual outside one octant"); // R3
        end
    endgenerate

endmodule

// File: rtl/p2r_gain_scale.sv
module p2r_gain_scale #(
    parameter int DW    = 24,
    parameter int OUT_W = 16,
    parameter int GUARD = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [DW-1:0]    x_i,
    input  logic signed [DW-1:0]    y_i,
    input  logic                    fmt_i,
    output logic signed [OUT_W-1:0] x_o,
    output logic signed [OUT_W-1:0] y_o,
    output logic                    fmt_o
);

    localparam int KQ_W = p2r_pkg::GAIN_FRAC + 1;
    localparam int PW   = DW + KQ_W;
    localparam int SH   = p2r_pkg::GAIN_FRAC + GUARD;
    localparam logic signed [KQ_W-1:0] KQ      = KQ_W'(p2r_pkg::GAIN_Q);
    localparam logic signed [PW-1:0]   HALF    = PW'(1) <<< (SH - 1);
    localparam logic signed [PW-1:0]   POS_LIM = PW'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [PW-1:0]   NEG_LIM = -POS_LIM;

    typedef struct packed {
        logic signed [OUT_W-1:0] x;
        logic signed [OUT_W-1:0] y;
        logic                    fmt;
    } scl_t;

    scl_t st_d, st_q;

    function automatic logic signed [OUT_W-1:0] scale_one(input logic signed [DW-1:0] v);
        logic signed [PW-1:0] prod;
        logic signed [PW-1:0] rnd;
        prod = PW'(v) * PW'(KQ);
        rnd  = prod + HALF;
        rnd  = rnd >>> SH;
        if (rnd > POS_LIM)      return POS_LIM[OUT_W-1:0];
        else if (rnd < NEG_LIM) return NEG_LIM[OUT_W-1:0];
        else                    return rnd[OUT_W-1:0];
    endfunction

    always_comb begin
        st_d.x   = scale_one(x_i);
        st_d.y   = scale_one(y_i);
        st_d.fmt = fmt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x_o   = st_q.x;
    assign y_o   = st_q.y;
    assign fmt_o = st_q.fmt;

endmodule

// File: rtl/p2r_out_format.sv
module p2r_out_format #(
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [OUT_W-1:0] x_i,
    input  logic signed [OUT_W-1:0] y_i,
    input  logic                    fmt_i,
    output logic [OUT_W-1:0]        i_code_o,
    output logic [OUT_W-1:0]        q_code_o
);

    localparam logic [OUT_W-1:0]        MID      = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    typedef struct packed {
        logic [OUT_W-1:0] i;
        logic [OUT_W-1:0] q;
    } code_t;

    code_t st_d, st_q;

    function automatic logic [OUT_W-1:0] encode(input logic signed [OUT_W-1:0] v, input logic obin);
        logic [OUT_W-2:0] mag;
        mag = v[OUT_W-1] ? (~v[OUT_W-2:0] + 1'b1) : v[OUT_W-2:0];
        return obin ? {~v[OUT_W-1], v[OUT_W-2:0]} : {1'b1, mag};
    endfunction

    always_comb begin
        st_d.i = encode(x_i, fmt_i);
        st_d.q = encode(y_i, fmt_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.i <= MID;
            st_q.q <= MID;
        end else begin
            st_q <= st_d;
        end
    end

    assign i_code_o = st_q.i;
    assign q_code_o = st_q.q;

    AST_MIN_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n) (x_i != MOST_NEG) && (y_i != MOST_NEG)) else $error("full-scale negative reached the encoder"); // R4
    AST_OFFSET_SIGN: assert property (@(posedge clk) disable iff (!rst_n) fmt_i |=> (st_q.i[OUT_W-1] != $past(x_i[OUT_W-1])) && (st_q.q[OUT_W-1] != $past(y_i[OUT_W-1]))) else $error("offset binary sign bit wrong"); // R5
    AST_UNSIGNED_FLAG: assert property (@(posedge clk) disable iff (!rst_n) !fmt_i |=> st_q.i[OUT_W-1] && st_q.q[OUT_W-1]) else $error("magnitude form top bit low"); // R6

endmodule

// File: rtl/polar_rect_cordic.sv
module polar_rect_cordic #(
    parameter int AMP_W  = 15,
    parameter int PH_W   = 32,
    parameter int ANG_W  = 24,
    parameter int DW     = 24,
    parameter int OUT_W  = 16,
    parameter int N_ITER = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AMP_W-1:0] amp_in,
    input  logic [PH_W-1:0]  phase_in,
    input  logic             fmt_obin,
    input  logic             oe_i_n,
    input  logic             oe_q_n,
    output logic [OUT_W-1:0] i_out,
    output logic [OUT_W-1:0] q_out,
    output logic             i_en,
    output logic             q_en
);

    localparam int GUARD = DW - AMP_W - 3;

    logic signed [DW-1:0]    rx [0:N_ITER];
    logic signed [DW-1:0]    ry [0:N_ITER];
    logic signed [ANG_W-1:0] rz [0:N_ITER];
    logic                    rf [0:N_ITER];

    logic signed [OUT_W-1:0] sx, sy;
    logic                    sf;
    logic [OUT_W-1:0]        i_code, q_code;

    p2r_quadrant_map #(
        .AMP_W(AMP_W), .PH_W(PH_W), .ANG_W(ANG_W), .DW(DW), .GUARD(GUARD)
    ) u_quad (
        .clk(clk), .rst_n(rst_n),
        .amp_i(amp_in), .phase_i(phase_in), .fmt_i(fmt_obin),
        .x_o(rx[0]), .y_o(ry[0]), .z_o(rz[0]), .fmt_o(rf[0])
    );

    generate
        for (genvar k = 0; k < N_ITER; k++) begin : g_rot
            p2r_micro_rot #(
                .DW(DW), .ANG_W(ANG_W), .IDX(k)
            ) u_rot (
                .clk(clk), .rst_n(rst_n),
                .x_i(rx[k]), .y_i(ry[k]), .z_i(rz[k]), .fmt_i(rf[k]),
                .x_o(rx[k+1]), .y_o(ry[k+1]), .z_o(rz[k+1]), .fmt_o(rf[k+1])
            );
        end
    endgenerate

    p2r_gain_scale #(
        .DW(DW), .OUT_W(OUT_W), .GUARD(GUARD)
    ) u_scale (
        .clk(clk), .rst_n(rst_n),
        .x_i(rx[N_ITER]), .y_i(ry[N_ITER]), .fmt_i(rf[N_ITER]),
        .x_o(sx), .y_o(sy), .fmt_o(sf)
    );

    p2r_out_format #(
        .OUT_W(OUT_W)
    ) u_fmt (
        .clk(clk), .rst_n(rst_n),
        .x_i(sx), .y_i(sy), .fmt_i(sf),
        .i_code_o(i_code), .q_code_o(q_code)
    );

    assign i_en  = ~oe_i_n;
    assign q_en  = ~oe_q_n;
    assign i_out = oe_i_n ? '0 : i_code;
    assign q_out = oe_q_n ? '0 : q_code;

    AST_RESET_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (i_code == 16'h8000) && (q_code == 16'h8000)) else $error("codes not mid-scale after reset"); // R9

endmodule

// File: tb/polar_rect_cordic_tb.sv
`timescale 1ns/1ps
module polar_rect_cordic_tb;

    localparam int  LAT  = 22;
    localparam real TWOPI = 6.283185307179586;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] amp_in = '0;
    logic [31:0] phase_in = '0;
    logic        fmt_obin = 1'b1;
    logic        oe_i_n = 1'b0;
    logic        oe_q_n = 1'b0;
    logic [15:0] i_out, q_out;
    logic        i_en, q_en;

    int n_checks = 0;
    int n_err    = 0;

    always #10 clk = ~clk;

    polar_rect_cordic u_dut (
        .clk(clk), .rst_n(rst_n), .amp_in(amp_in), .phase_in(phase_in),
        .fmt_obin(fmt_obin), .oe_i_n(oe_i_n), .oe_q_n(oe_q_n),
        .i_out(i_out), .q_out(q_out), .i_en(i_en), .q_en(q_en)
    );

    typedef struct packed {
        logic [14:0] amp;
        logic [31:0] ph;
        logic        fmt;
    } vec_t;

    localparam vec_t TABLE [16] = '{
        '{15'h7FFF, 32'h0000_0000, 1'b1},
        '{15'h7FFF, 32'h4000_0000, 1'b1},
        '{15'h7FFF, 32'h8000_0000, 1'b1},
        '{15'h7FFF, 32'hC000_0000, 1'b0},
        '{15'h4000, 32'h2000_0000, 1'b1},
        '{15'h4000, 32'h6000_0000, 1'b0},
        '{15'h1234, 32'hA000_0000, 1'b1},
        '{15'h7FFF, 32'hE000_0000, 1'b0},
        '{15'h7FFF, 32'hFFFF_FF00, 1'b1},
        '{15'h0000, 32'h1234_5678, 1'b1},
        '{15'h0001, 32'h9ABC_DEF0, 1'b0},
        '{15'h5555, 32'h1FFF_FF00, 1'b1},
        '{15'h5555, 32'h2000_0100, 1'b0},
        '{15'h2AAA, 32'h7FFF_FFFF, 1'b1},
        '{15'h7FFF, 32'h3FFF_FF00, 1'b0},
        '{15'h6000, 32'h5555_5555, 1'b1}
    };

    function automatic vec_t get_vec(input int mode, input int k);
        vec_t v;
        case (mode)
            0:       v = TABLE[k];
            1:       v = '{amp: 15'h7FFF, ph: {k[7:0], 24'h00A5C3}, fmt: k[0]};
            default: v = '{amp: 15'h7FFF, ph: 32'h1FE0_0000 + 32'(k) * 32'h0000_4000, fmt: 1'b1};
        endcase
        return v;
    endfunction

    task automatic apply(input vec_t v);
        amp_in   = v.amp;
        phase_in = v.ph;
        fmt_obin = v.fmt;
    endtask

    task automatic check_one(input logic [15:0] code, input logic obin, input real rv,
                             input string lane, input string tag);
        int  val;
        real d, ar;
        n_checks++;
        if (obin) begin
            val = int'(code) - 32768;
            d   = real'(val) - rv;
            if (d < 0.0) d = -d;
            if (d > 2.0) begin
                n_err++;
                $display("FAIL %s R5 lane %s actual=%0d expected=%0.2f", tag, lane, val, rv);
            end
            if (rv < -32700.0) begin
                n_checks++;
                if (val < -32767) begin
                    n_err++;
                    $display("FAIL R4 lane %s actual=%0d expected>=-32767", lane, val);
                end
            end
        end else begin
            val = int'(code[14:0]);
            ar  = (rv < 0.0) ? -rv : rv;
            d   = real'(val) - ar;
            if (d < 0.0) d = -d;
            if (!code[15] || d > 2.0) begin
                n_err++;
                $display("FAIL %s R6 lane %s actual=%h expected=1|%0.2f", tag, lane, code, ar);
            end
        end
    endtask

    task automatic check_vec(input vec_t v, input string tag);
        real th;
        th = real'(v.ph[31:8]) / 16777216.0 * TWOPI;
        check_one(i_out, v.fmt, real'(v.amp) * $cos(th), "I", tag);
        check_one(q_out, v.fmt, real'(v.amp) * $sin(th), "Q", tag);
    endtask

    task automatic check_eq(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Stream n vectors back to back; after edge c the outputs hold vector c-(LAT-1).
    task automatic stream(input int mode, input int n, input string tag);
        vec_t idle;
        idle = '{amp: 15'h0, ph: 32'h0, fmt: 1'b1};
        for (int c = 0; c < n + LAT - 1; c++) begin
            if (c < n) apply(get_vec(mode, c));
            else       apply(idle);
            @(posedge clk);
            @(negedge clk);
            if (c >= LAT - 1) check_vec(get_vec(mode, c - LAT + 1), tag);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [15:0] cap_i, cap_q;
        vec_t        idle;
        idle = '{amp: 15'h0, ph: 32'h0, fmt: 1'b1};
        apply(idle);

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq(i_out, 16'h8000, "R9 i_out in reset");
        check_eq(q_out, 16'h8000, "R9 q_out in reset");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_eq(i_out, 16'h8000, "R9 i_out after release");
        check_eq(q_out, 16'h8000, "R9 q_out after release");
        check_bit(i_en, 1'b1, "R9 i_en");
        check_bit(q_en, 1'b1, "R9 q_en");
        repeat (LAT) @(posedge clk);
        @(negedge clk);

        // R1: single-cycle pulse, exact arrival edge
        apply('{amp: 15'h7FFF, ph: 32'h0, fmt: 1'b1});
        for (int k = 1; k <= LAT + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 1) apply(idle);
            if (k == LAT - 1) check_eq(i_out, 16'h8000, "R1 before arrival");
            if (k == LAT)     check_one(i_out, 1'b1, 32767.0, "I", "R1");
            if (k == LAT + 1) check_eq(i_out, 16'h8000, "R1 one-cycle result");
        end

        // Table walk: quadrant and octant boundaries, mixed formats
        stream(0, 16, "R3");
        // Full-turn sweep with the format flag alternating every sample
        stream(1, 256, "R7");
        // Circle sweep near 45 degrees at full radius
        stream(2, 3000, "R2");

        // R8: independent output enables
        apply('{amp: 15'h7FFF, ph: 32'h0, fmt: 1'b1});
        repeat (LAT + 1) @(posedge clk);
        @(negedge clk);
        oe_i_n = 1'b1;
        #1;
        check_bit(i_en, 1'b0, "R8 i_en released");
        check_eq(i_out, 16'h0000, "R8 i_out released");
        check_bit(q_en, 1'b1, "R8 q_en held");
        check_one(q_out, 1'b1, 0.0, "Q", "R8");
        oe_i_n = 1'b0;
        oe_q_n = 1'b1;
        #1;
        check_bit(q_en, 1'b0, "R8 q_en released");
        check_eq(q_out, 16'h0000, "R8 q_out released");
        check_one(i_out, 1'b1, 32767.0, "I", "R8");
        oe_q_n = 1'b0;

        // R10: low phase byte ignored
        @(negedge clk);
        apply('{amp: 15'h7FFF, ph: 32'h2345_6700, fmt: 1'b1});
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        cap_i = i_out;
        cap_q = q_out;
        check_vec('{amp: 15'h7FFF, ph: 32'h2345_6700, fmt: 1'b1}, "R10");
        apply('{amp: 15'h7FFF, ph: 32'h2345_67FF, fmt: 1'b1});
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        check_eq(i_out, cap_i, "R10 i_out low byte");
        check_eq(q_out, cap_q, "R10 q_out low byte");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule